// File: doc/BRIEF.md
# Chunked FIFO Transfer Sequencer

This block runs one programmed data transfer at a time between a register-style bus and a card-side 16-bit stream, passing every beat through a 512-byte FIFO. Software writes a single control word holding the byte count, the direction and a start bit. The sequencer then hands the data across in 512-byte chunks. For each chunk it pulses a buffer-available event: on host-to-card transfers when the FIFO has room for the chunk, and on card-to-host transfers when the chunk is present. It pulses a done event once the whole count has crossed the FIFO.

The bus reaches the FIFO through two 512-byte address windows. Every address inside a window selects the same FIFO port, so a burst engine can use either incrementing or fixed addresses. Each bus access moves one 16-bit beat in the low half of the 32-bit bus word.

The card side is two valid/ready streams. A beat moves on a rising edge where valid and ready are both high. The block holds `cout_data` steady while `cout_valid` is high and `cout_ready` is low. It lowers `cin_ready` whenever the FIFO is full or the card side has already moved its share of the count, so the card source can be back-pressured for any number of cycles.

Top module: `chunk_xfer_seq`

## Requirements
- R1: After reset the block is idle. The control word reads as zero, `cout_valid` and `cin_ready` are low, and no event pulses.
- R2: The control word sits at byte offset 0x01C. Bit 31 is start and bit 30 is direction (1 = host to card, 0 = card to host). Bits [17:0] hold the byte count, and an odd count is rounded up to whole 16-bit beats. Writing start=1 while idle launches a transfer. The word reads back as start (high while running), direction, and remaining bytes in [17:0], with bits [29:18] reading zero.
- R3: In the host-to-card direction, bus writes anywhere in 0x200..0x3FF push the low 16 bits into the FIFO. These values leave on the `cout` stream in the same order. `cout_data` holds steady while `cout_valid` is high and `cout_ready` is low.
- R4: In the card-to-host direction, `cin` beats are accepted only while the FIFO has space and card-side count remains. Bus reads anywhere in 0x400..0x5FF return these values, in order, in bits [15:0].
- R5: `evt_buf_avail` pulses for one cycle once per 512-byte chunk. It fires when the bus has moved every beat already granted and the FIFO has the whole chunk free (host-to-card) or present (card-to-host).
- R6: When the count is not a multiple of 512, the last chunk raises `evt_buf_avail` as soon as its remaining bytes are free or present.
- R7: `evt_done` pulses for one cycle after the full count has crossed the FIFO. Start then reads 0 and the count reads 0. A start with a count of zero completes at once.
- R8: Writing the control word with start=0 during a transfer stops it at once. Both stream handshakes drop, the FIFO empties, and `evt_done` does not pulse.
- R9: While a transfer runs, the count field reads the bytes the slower side still has to move: the card side for host-to-card, the bus side for card-to-host.
- R10: A window read while the FIFO is empty returns 0. A window write while the FIFO is full, or after the bus side has moved its whole count, is dropped. Either case pulses `evt_err` and stops the transfer.
- R11: A start with a count above 0x20000 bytes pulses `evt_err` and does not start. A count of exactly 0x20000 starts normally.
- R12: Window accesses while idle, or in the window of the other direction, are ignored. They raise no error, read 0, and put no data into the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe, one access per cycle |
| bus_rd | input | 1 | Bus read strobe, one access per cycle |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, valid in the cycle of `bus_rd` |
| cin_valid | input | 1 | Card-to-host beat valid |
| cin_ready | output | 1 | Block can take a card-to-host beat |
| cin_data | input | 16 | Card-to-host beat data |
| cout_valid | output | 1 | Host-to-card beat valid |
| cout_ready | input | 1 | Card takes the host-to-card beat |
| cout_data | output | 16 | Host-to-card beat data |
| evt_buf_avail | output | 1 | One-cycle pulse: a chunk is free or present |
| evt_done | output | 1 | One-cycle pulse: the whole count has moved |
| evt_err | output | 1 | One-cycle pulse: underflow, overflow or oversize count |

## Verification
The bench targets chunk boundaries. A 600-byte read must give exactly two buffer-available pulses, with the second covering only 44 beats. A design that rounds the last chunk up to 512 bytes would stall with no second pulse, and one that raised pulses per word would show hundreds. The remaining-count readback is checked mid-transfer, which catches a design that reports the leading side instead of the trailing side. Abort is checked to give no done pulse and to drop `cin_ready`. An underflowing read must return zero and stop the transfer rather than hand out stale FIFO contents. A count one beat above the limit must be refused while the exact limit is accepted. A window write made while idle must never reach the card stream of the next transfer.

// File: rtl/cxs_pkg.sv
package cxs_pkg;
  typedef enum logic {XDIR_RD = 1'b0, XDIR_WR = 1'b1} xdir_e;
  localparam int unsigned CTRL_OFS  = 32'h01C;
  localparam int unsigned WWIN_IDX  = 1;   // 0x200..0x3FF
  localparam int unsigned RWIN_IDX  = 2;   // 0x400..0x5FF
  localparam int unsigned START_BIT = 31;
  localparam int unsigned DIR_BIT   = 30;
endpackage

// File: rtl/cxs_fifo.sv
module cxs_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 256,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      level <= level + LW'(do_push) - LW'(do_pop);
    end
  end
endmodule

// File: rtl/cxs_chunk_gate.sv
module cxs_chunk_gate #(
  parameter int CHUNK = 256,
  parameter int CW    = 18,
  parameter int LW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_beats,
  input  logic          clear,
  input  logic          enable,
  input  logic [CW-1:0] host_left,
  input  logic [LW-1:0] avail,
  output logic          evt
);
  logic [CW-1:0] grant_left, step;
  logic          fire;

  // last chunk may be shorter than a full one
  assign step = (grant_left < CW'(CHUNK)) ? grant_left : CW'(CHUNK);
  assign fire = enable && (grant_left != '0) && (host_left <= grant_left)
                && (CW'(avail) >= step);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_left <= '0;
      evt        <= 1'b0;
    end else begin
      evt <= 1'b0;
      if (clear) begin
        grant_left <= '0;
      end else if (load) begin
        grant_left <= load_beats;
      end else if (fire) begin
        grant_left <= grant_left - step;
        evt        <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/chunk_xfer_seq.sv
module chunk_xfer_seq
  import cxs_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int BUS_W      = 32,
  parameter int DATA_W     = 16,
  parameter int FIFO_BYTES = 512,
  parameter int CNT_W      = 18,
  parameter int MAX_BYTES  = 32'h20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              cin_valid,
  output logic              cin_ready,
  input  logic [DATA_W-1:0] cin_data,
  output logic              cout_valid,
  input  logic              cout_ready,
  output logic [DATA_W-1:0] cout_data,
  output logic              evt_buf_avail,
  output logic              evt_done,
  output logic              evt_err
);
  localparam int BPB    = DATA_W / 8;
  localparam int DEPTH  = FIFO_BYTES / BPB;
  localparam int LW     = $clog2(DEPTH) + 1;
  localparam int WIN_SH = $clog2(FIFO_BYTES);

  // decode
  logic sel_ctrl, sel_wwin, sel_rwin;
  assign sel_ctrl = (bus_addr == ADDR_W'(CTRL_OFS));
  assign sel_wwin = ((bus_addr >> WIN_SH) == ADDR_W'(WWIN_IDX));
  assign sel_rwin = ((bus_addr >> WIN_SH) == ADDR_W'(RWIN_IDX));

  // state
  logic              active;
  xdir_e             dir;
  logic [CNT_W-1:0]  host_left, card_left;

  // control word decode
  logic [CNT_W-1:0]  wcnt, wbeats;
  logic [CNT_W:0]    wsum;
  logic              ctrl_wr, go, stop, too_big, is_wr;
  assign ctrl_wr = bus_wr & sel_ctrl;
  assign wcnt    = bus_wdata[CNT_W-1:0];
  assign wsum    = {1'b0, wcnt} + (CNT_W+1)'(BPB - 1);
  assign wbeats  = CNT_W'(wsum / BPB);
  assign too_big = {1'b0, wcnt} > (CNT_W+1)'(MAX_BYTES);
  assign go      = ctrl_wr & bus_wdata[START_BIT] & ~active;
  assign stop    = ctrl_wr & ~bus_wdata[START_BIT] & active;
  assign is_wr   = (dir == XDIR_WR);

  // FIFO
  logic              f_push, f_pop, f_full, f_empty, f_flush;
  logic [DATA_W-1:0] f_wdata, f_rdata;
  logic [LW-1:0]     f_level;

  // bus-side window traffic
  logic host_wr_try, host_rd_try, wr_bad, rd_bad, host_push, host_pop;
  assign host_wr_try = bus_wr & sel_wwin & active & is_wr;
  assign host_rd_try = bus_rd & sel_rwin & active & ~is_wr;
  assign wr_bad      = host_wr_try & (f_full | (host_left == '0));
  assign rd_bad      = host_rd_try & f_empty;
  assign host_push   = host_wr_try & ~wr_bad;
  assign host_pop    = host_rd_try & ~rd_bad;

  // card-side streams
  logic beat_in, beat_out, host_move, card_move, finishing;
  assign cin_ready  = active & ~is_wr & ~f_full & (card_left != '0);
  assign cout_valid = active & is_wr & ~f_empty;
  assign cout_data  = f_rdata;
  assign beat_in    = cin_valid & cin_ready;
  assign beat_out   = cout_valid & cout_ready;
  assign host_move  = host_push | host_pop;
  assign card_move  = is_wr ? beat_out : beat_in;
  assign finishing  = active & (host_left == '0) & (card_left == '0);

  assign f_push  = is_wr ? host_push : beat_in;
  assign f_wdata = is_wr ? bus_wdata[DATA_W-1:0] : cin_data;
  assign f_pop   = is_wr ? beat_out : host_pop;
  assign f_flush = stop | wr_bad | rd_bad;

  cxs_fifo #(.W(DATA_W), .DEPTH(DEPTH), .LW(LW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(f_flush),
    .push(f_push), .wdata(f_wdata), .pop(f_pop),
    .rdata(f_rdata), .level(f_level), .full(f_full), .empty(f_empty)
  );

  logic [LW-1:0] avail;
  assign avail = is_wr ? (LW'(DEPTH) - f_level) : f_level;

  cxs_chunk_gate #(.CHUNK(DEPTH), .CW(CNT_W), .LW(LW)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .load(go & ~too_big), .load_beats(wbeats),
    .clear(f_flush | finishing), .enable(active),
    .host_left(host_left), .avail(avail), .evt(evt_buf_avail)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      dir       <= XDIR_RD;
      host_left <= '0;
      card_left <= '0;
      evt_done  <= 1'b0;
      evt_err   <= 1'b0;
    end else begin
      evt_done <= 1'b0;
      evt_err  <= 1'b0;
      if (go) begin
        if (too_big) begin
          evt_err <= 1'b1;
        end else if (wbeats == '0) begin
          evt_done  <= 1'b1;
          host_left <= '0;
          card_left <= '0;
        end else begin
          active    <= 1'b1;
          dir       <= xdir_e'(bus_wdata[DIR_BIT]);
          host_left <= wbeats;
          card_left <= wbeats;
        end
      end else if (stop) begin
        active <= 1'b0;
      end else if (wr_bad || rd_bad) begin
        active  <= 1'b0;
        evt_err <= 1'b1;
      end else if (finishing) begin
        active   <= 1'b0;
        evt_done <= 1'b1;
      end else if (active) begin
        host_left <= host_left - CNT_W'(host_move);
        card_left <= card_left - CNT_W'(card_move);
      end
    end
  end

  // readback
  logic [CNT_W-1:0] remaining;
  assign remaining = CNT_W'((is_wr ? card_left : host_left) * BPB);

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl) begin
      bus_rdata[START_BIT]   = active;
      bus_rdata[DIR_BIT]     = is_wr;
      bus_rdata[CNT_W-1:0]   = remaining;
    end else if (host_pop) begin
      bus_rdata[DATA_W-1:0]  = f_rdata;
    end
  end
endmodule

// File: rtl/cxs_checker.sv
module cxs_checker #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  parameter int LW     = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              cout_valid,
  input logic              cout_ready,
  input logic [DATA_W-1:0] cout_data,
  input logic              cin_ready,
  input logic              evt_done,
  input logic              evt_err,
  input logic [LW-1:0]     fifo_level
);
  // R3: a stalled outbound beat keeps its data until taken
  a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cout_valid && !cout_ready && !bus_wr) |=> (cout_valid && $stable(cout_data)));

  // R4: inbound ready never offered into a full FIFO
  a_r4_in_room: assert property (@(posedge clk) disable iff (!rst_n)
    cin_ready |-> (fifo_level < LW'(DEPTH)));

  // R7: completion leaves an empty FIFO and quiet streams
  a_r7_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> (fifo_level == '0 && !cout_valid && !cin_ready));

  // R10: an error halts both stream handshakes
  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |-> (!cout_valid && !cin_ready));
endmodule

bind chunk_xfer_seq cxs_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
  .cout_valid(cout_valid), .cout_ready(cout_ready), .cout_data(cout_data),
  .cin_ready(cin_ready), .evt_done(evt_done), .evt_err(evt_err),
  .fifo_level(f_level)
);

// File: tb/chunk_xfer_seq_tb_top.sv
`timescale 1ns/100ps
module chunk_xfer_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        cin_valid = 1'b0, cin_ready;
  logic [15:0] cin_data = '0;
  logic        cout_valid, cout_ready = 1'b0;
  logic [15:0] cout_data;
  logic        evt_buf_avail, evt_done, evt_err;

  int checks = 0, fails = 0;
  int nbuf = 0, ndone = 0, nerr = 0;
  logic [15:0] sink_q[$];

  always #2 clk = ~clk;

  chunk_xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cin_valid(cin_valid), .cin_ready(cin_ready), .cin_data(cin_data),
    .cout_valid(cout_valid), .cout_ready(cout_ready), .cout_data(cout_data),
    .evt_buf_avail(evt_buf_avail), .evt_done(evt_done), .evt_err(evt_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (evt_buf_avail) nbuf++;
      if (evt_done) ndone++;
      if (evt_err) nerr++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #0.5 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_buf(input int target);
    for (int n = 0; n < 3000 && nbuf < target; n++) begin
      @(negedge clk); #0.5;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sink(input int n);
    int got = 0;
    for (int cyc = 0; got < n && cyc < 20000; cyc++) begin
      @(negedge clk);
      cout_ready = (cyc % 3) != 1;
      #0.5;
      if (cout_valid && cout_ready) begin
        sink_q.push_back(cout_data);
        got++;
      end
    end
    @(negedge clk);
    cout_ready = 1'b0;
  endtask

  task automatic source(input int n);
    int i = 0;
    for (int cyc = 0; i < n && cyc < 20000; cyc++) begin
      @(negedge clk);
      cin_valid = (cyc % 4) != 3;
      cin_data  = 16'h5000 ^ 16'(i * 3);
      #0.5;
      if (cin_valid && cin_ready) i++;
    end
    @(negedge clk);
    cin_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bread(12'h01C, d);
    chk(d == 32'h0, "R1 ctrl after reset", d, 32'h0);
    chk(!cout_valid && !cin_ready, "R1 streams idle", {cout_valid, cin_ready}, 0);
    chk(nbuf + ndone + nerr == 0, "R1 no events", nbuf + ndone + nerr, 0);
  endtask

  task automatic t_write_1024;
    int b0 = nbuf, d0 = ndone, e0 = nerr, bad = 0;
    logic [31:0] d;
    sink_q.delete();
    bwrite(12'h01C, 32'hC000_0400);
    fork
      begin
        for (int k = 0; k < 2; k++) begin
          wait_buf(b0 + k + 1);
          for (int j = 0; j < 256; j++)
            bwrite(12'h200 + 12'((j * 4) & 12'h1FC), 32'(16'hA000 + 16'(k * 256 + j)));
        end
      end
      sink(512);
    join
    idle(4);
    for (int i = 0; i < 512; i++)
      if (i >= sink_q.size() || sink_q[i] != 16'(16'hA000 + i)) bad++;
    chk(bad == 0 && sink_q.size() == 512, "R3 outbound data order", bad, 0);
    chk(nbuf - b0 == 2, "R5 two chunk events", nbuf - b0, 2);
    chk(ndone - d0 == 1, "R7 done after write", ndone - d0, 1);
    chk(nerr == e0, "R3 no error", nerr - e0, 0);
    bread(12'h01C, d);
    chk(d == 32'h4000_0000, "R7 start and count cleared", d, 32'h4000_0000);
  endtask

  task automatic t_read_600;
    int b0 = nbuf, d0 = ndone, e0 = nerr, bad = 0;
    logic [31:0] d, mid;
    bwrite(12'h01C, 32'h8000_0258);
    fork
      source(300);
      begin
        wait_buf(b0 + 1);
        for (int j = 0; j < 256; j++) begin
          bread(12'h400 + 12'((j * 12) & 12'h1FC), d);
          if (d != 32'(16'h5000 ^ 16'(j * 3))) bad++;
        end
        wait_buf(b0 + 2);
        bread(12'h01C, mid);
        for (int j = 256; j < 300; j++) begin
          bread(12'h5FC, d);
          if (d != 32'(16'h5000 ^ 16'(j * 3))) bad++;
        end
      end
    join
    idle(4);
    chk(bad == 0, "R4 inbound data via aliased window", bad, 0);
    chk(mid == 32'h8000_0058, "R9 remaining mid-transfer", mid, 32'h8000_0058);
    chk(nbuf - b0 == 2, "R6 partial last chunk event", nbuf - b0, 2);
    chk(ndone - d0 == 1, "R7 done after read", ndone - d0, 1);
    chk(nerr == e0 && !cin_ready, "R4 card side stops at count", {nerr - e0, cin_ready}, 0);
  endtask

  task automatic t_abort;
    int d0 = ndone, e0 = nerr;
    logic [31:0] d;
    bwrite(12'h01C, 32'h8000_0400);
    bread(12'h01C, d);
    chk(d == 32'h8000_0400, "R2 running readback", d, 32'h8000_0400);
    chk(cin_ready == 1'b1, "R4 ready while running", cin_ready, 1);
    bwrite(12'h01C, 32'h0);
    bread(12'h01C, d);
    chk(d[31] == 1'b0 && !cin_ready, "R8 abort stops", d, 32'h0000_0400);
    idle(20);
    chk(ndone == d0 && nerr == e0, "R8 no done on abort", ndone - d0, 0);
  endtask

  task automatic t_underflow;
    int e0 = nerr;
    logic [31:0] d;
    bwrite(12'h01C, 32'h8000_0040);
    bread(12'h404, d);
    chk(d == 32'h0, "R10 empty read returns 0", d, 0);
    idle(2);
    chk(nerr - e0 == 1, "R10 error event", nerr - e0, 1);
    bread(12'h01C, d);
    chk(d[31] == 1'b0 && !cin_ready, "R10 transfer stopped", d[31], 0);
  endtask

  task automatic t_limits;
    int e0 = nerr, d0 = ndone;
    logic [31:0] d;
    bwrite(12'h01C, 32'h8002_0002);
    idle(2);
    bread(12'h01C, d);
    chk(nerr - e0 == 1 && d[31] == 1'b0, "R11 oversize rejected", d, 0);
    bwrite(12'h01C, 32'h8002_0000);
    bread(12'h01C, d);
    chk(d == 32'h8002_0000, "R11 exact limit accepted", d, 32'h8002_0000);
    bwrite(12'h01C, 32'h0);
    bwrite(12'h01C, 32'h8000_0000);
    idle(2);
    chk(ndone - d0 == 1, "R7 zero count completes", ndone - d0, 1);
  endtask

  task automatic t_idle_ignore;
    int e0 = nerr, d0 = ndone;
    logic [31:0] d;
    bwrite(12'h210, 32'h0000_1234);
    bread(12'h420, d);
    chk(d == 32'h0, "R12 idle read gives 0", d, 0);
    idle(2);
    chk(nerr == e0 && !cout_valid, "R12 idle access no effect", nerr - e0, 0);
    sink_q.delete();
    bwrite(12'h01C, 32'hC000_0002);
    fork
      begin
        wait_buf(nbuf + 1);
        bread(12'h400, d);
        bwrite(12'h3FC, 32'h0000_BEEF);
      end
      sink(1);
    join
    idle(4);
    chk(sink_q.size() == 1 && sink_q[0] == 16'hBEEF, "R12 stale write not sent",
        sink_q.size() > 0 ? 32'(sink_q[0]) : 32'hFFFF_FFFF, 32'h0000_BEEF);
    chk(ndone - d0 == 1 && nerr == e0, "R12 wrong window ignored", nerr - e0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_write_1024();
    t_read_600();
    t_abort();
    t_underflow();
    t_limits();
    t_idle_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule